// File: doc/BRIEF.md
# I2C Register Control Port

This block is a target on a two-wire serial control bus. It gives a host read and write access to a small bank of 8-bit control registers. A system clock oversamples the bus clock and data lines. The block finds bus START and STOP conditions and compares the 7-bit address in each transfer with its own. For reads it pulls the data line low through an open-drain enable. The bank contents are also driven out in parallel, so the rest of the chip can use the settings.

Each write transfer begins with an index byte. Its low nibble picks a register and its top bit turns on stepping. With stepping on, the index moves to the next register after every data byte, which allows burst access. With stepping off, every byte goes to the same register. The strap input sets the lowest address bit. A falling edge on the strap input moves the port for good into the other serial mode, and after that the two-wire engine ignores the bus.

Top module: `i2c_regport`

## Requirements
- R1: After reset, every register is 0x00, the index and its stepping flag are 0, `sda_oe_o` is 0 and `spi_mode_o` is 0.
- R2: The port answers 7-bit address {0,0,1,0,0,0,strap}. Address-byte bit 0 is the direction, with 0 meaning write. The port acknowledges a matching address by pulling SDA low for the ninth clock, and it changes its SDA drive only while SCL is low.
- R3: The port does not acknowledge an address byte that does not match. It then ignores every later byte, and writes nothing, until the next START.
- R4: In a write transfer, the first byte after the address loads the index. Bits 3:0 select the register, bit 7 is the stepping flag and bits 6:4 have no effect. The port acknowledges this byte.
- R5: Every later byte of a write transfer is stored in the register the index selects, shows on `regs_o[8*i +: 8]`, and is acknowledged.
- R6: With the stepping flag at 0, the index stays the same across data bytes, so all of them hit one register.
- R7: With the stepping flag at 1, the index moves up by one after each data byte, read or written, and goes from 15 back to 0.
- R8: In a read transfer, the port sends the register the current index selects, MSB first, starting right after the address acknowledge. It keeps sending while the host acknowledges.
- R9: A host NACK ends a read, and SDA stays released after it. A START or STOP in the middle of a byte drops that byte without writing it.
- R10: A falling edge on `strap_i` after reset sets `spi_mode_o`, which stays set. From then on the port drives SDA never and writes no register.
- R11: The index and stepping flag keep their values from one transfer to the next. A read that sends no index byte uses the value left by the previous transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| strap_i | input | 1 | Address LSB strap; a falling edge selects the other serial mode |
| spi_mode_o | output | 1 | Sticky flag showing the two-wire engine is disabled |
| regs_o | output | NREG*8 | Parallel view of the register bank, register i in bits 8*i+7:8*i |

## Verification
The bench drives the bus wires from the host side, resolves them as a wired-AND with the block's pull-down, and checks the registers against a model of the bank and index. Random bursts with random reserved bits and random stepping flags reach the 15-to-0 wrap. A design that skipped the wrap, or that stepped the index on the index byte itself, would put data in the wrong registers. Directed cases cover a mismatched address followed by data, a START in the middle of a byte, a read that reuses the index from the previous transfer, and a host NACK. A design that got these wrong would write stray bytes or hold SDA low. The last case changes the strap to high, and then from high to low. This checks that the address moves with the strap and that the mode switch stays set.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } port_st_e;

   typedef enum logic [1:0] {
      BK_ADDR,
      BK_IDX,
      BK_DATA
   } byte_kind_e;
endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_regport_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_regport_bank.sv
module i2c_regport_bank #(
   parameter int NREG = 16,
   parameter int DW   = 8,
   localparam int AW  = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [DW-1:0]    wdata,
   input  logic [AW-1:0]    raddr,
   output logic [DW-1:0]    rdata,
   output logic [NREG*DW-1:0] flat
);
   logic [DW-1:0] mem [NREG];

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              mem[g] <= '0;
            else if (we && waddr == AW'(g))          mem[g] <= wdata;
         end
         assign flat[g*DW +: DW] = mem[g];
      end
   endgenerate

   assign rdata = mem[raddr];

   // R3
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(flat));
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
   parameter int          NREG        = 16,
   parameter int          SYNC_STAGES = 2,
   parameter logic [5:0]  ADDR_HI     = 6'b001000,
   localparam int         DW          = i2c_regport_pkg::BYTE_W,
   localparam int         PW          = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe_o,
   input  logic               strap_i,
   output logic               spi_mode_o,
   output logic [NREG*DW-1:0] regs_o
);
   import i2c_regport_pkg::*;

   generate
      if (NREG != (1 << PW) || PW > 4 || PW < 1) begin : g_bad_nreg
         $error("i2c_regport: NREG must be a power of two from 2 to 16");
      end
   endgenerate

   logic [2:0] pin_s, pin_q;
   i2c_regport_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({strap_i, sda_i, scl_i}), .q(pin_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= '0;
      else        pin_q <= pin_s;
   end

   logic scl_s, sda_s, strap_s;
   logic scl_rise, scl_fall, start_det, stop_det, strap_fall;
   assign scl_s      = pin_s[0];
   assign sda_s      = pin_s[1];
   assign strap_s    = pin_s[2];
   assign scl_rise   = scl_s & ~pin_q[0];
   assign scl_fall   = ~scl_s & pin_q[0];
   assign start_det  = scl_s & pin_q[0] & pin_q[1] & ~sda_s;
   assign stop_det   = scl_s & pin_q[0] & ~pin_q[1] & sda_s;
   assign strap_fall = pin_q[2] & ~strap_s;

   port_st_e   st;
   byte_kind_e bk;
   logic [DW-1:0] sh;
   logic [3:0]    bc;
   logic          rw, incr, oe, spi, hack;
   logic [PW-1:0] idx;
   logic [DW-1:0] rdata;
   logic          we;
   logic          addr_hit;

   assign addr_hit = (sh[7:1] == {ADDR_HI, strap_s});
   assign we = !spi && !strap_fall && !start_det && !stop_det &&
               st == ST_RX && bk == BK_DATA && scl_fall && bc == 4'd8;

   i2c_regport_bank #(.NREG(NREG), .DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(idx), .wdata(sh),
      .raddr(idx), .rdata(rdata), .flat(regs_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         bk   <= BK_ADDR;
         sh   <= '0;
         bc   <= '0;
         rw   <= 1'b0;
         incr <= 1'b0;
         idx  <= '0;
         oe   <= 1'b0;
         spi  <= 1'b0;
         hack <= 1'b0;
      end else begin
         if (strap_fall) spi <= 1'b1;
         if (spi || strap_fall) begin
            st <= ST_IDLE;
            oe <= 1'b0;
         end else if (start_det) begin
            st <= ST_RX;
            bk <= BK_ADDR;
            bc <= '0;
            oe <= 1'b0;
         end else if (stop_det) begin
            st <= ST_IDLE;
            oe <= 1'b0;
         end else begin
            unique case (st)
               ST_RX: begin
                  if (scl_rise) begin
                     sh <= {sh[6:0], sda_s};
                     bc <= bc + 4'd1;
                  end else if (scl_fall && bc == 4'd8) begin
                     unique case (bk)
                        BK_ADDR: begin
                           if (addr_hit) begin
                              rw <= sh[0];
                              oe <= 1'b1;
                              st <= ST_ACK;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        BK_IDX: begin
                           idx  <= sh[PW-1:0];
                           incr <= sh[7];
                           oe   <= 1'b1;
                           st   <= ST_ACK;
                        end
                        default: begin
                           if (incr) idx <= idx + 1'b1;
                           oe <= 1'b1;
                           st <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bc <= '0;
                     if (bk == BK_ADDR && rw) begin
                        st <= ST_TX;
                        sh <= rdata;
                        oe <= ~rdata[7];
                     end else begin
                        st <= ST_RX;
                        oe <= 1'b0;
                        bk <= (bk == BK_ADDR) ? BK_IDX : BK_DATA;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bc == 4'd7) begin
                        oe <= 1'b0;
                        st <= ST_MACK;
                        if (incr) idx <= idx + 1'b1;
                     end else begin
                        bc <= bc + 4'd1;
                        sh <= {sh[6:0], 1'b0};
                        oe <= ~sh[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     hack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (hack) begin
                        st <= ST_TX;
                        sh <= rdata;
                        oe <= ~rdata[7];
                        bc <= '0;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o   = oe;
   assign spi_mode_o = spi;

   // R2
   drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> !scl_s);
   // R10
   spi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi |=> spi);
   // R10
   spi_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi |-> !oe);
   // R7
   idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && incr) |=> idx == $past(idx) + 1'b1);
   // R6
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !incr) |=> $stable(idx));
endmodule

// File: tb/tb_i2c_regport.sv
module tb_i2c_regport;
   localparam int NREG = 16;
   localparam int Q    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic strap = 1'b0;
   logic sda_oe, spi_mode;
   logic [NREG*8-1:0] regs;
   wire sda_line = m_sda & ~sda_oe;

   always #2 clk = ~clk;

   i2c_regport #(.NREG(NREG)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .strap_i(strap), .spi_mode_o(spi_mode), .regs_o(regs));

   int nchk = 0;
   int nfail = 0;
   logic [7:0] model [NREG];
   logic [3:0] m_idx = '0;
   logic       m_inc = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] next_idx(input logic [3:0] p, input logic inc);
      return inc ? p + 4'd1 : p;
   endfunction

   function automatic logic [7:0] addr_byte(input logic s, input logic rd);
      return {6'b001000, s, rd};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b1; tick(Q);
   endtask

   task automatic bit_out(input logic b);
      m_sda = b;    tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bit_in(output logic b);
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      b = sda_line; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic x;
      for (int i = 7; i >= 0; i--) bit_out(d[i]);
      bit_in(x);
      ack = ~x;
   endtask

   task automatic recv_byte(input logic ack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) bit_in(d[i]);
      bit_out(~ack);
   endtask

   task automatic check_bank(input string req);
      bit ok = 1'b1;
      int bad = 0;
      for (int i = 0; i < NREG; i++)
         if (regs[i*8 +: 8] !== model[i]) begin ok = 1'b0; bad = i; end
      chk(ok, req, regs[bad*8 +: 8], model[bad]);
   endtask

   task automatic do_write(input logic [7:0] ib, input int n);
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte(addr_byte(strap, 1'b0), a);
      chk(a, "R2 address ack", a, 1);
      send_byte(ib, a);
      chk(a, "R4 index ack", a, 1);
      m_idx = ib[3:0];
      m_inc = ib[7];
      for (int k = 0; k < n; k++) begin
         d = 8'($urandom);
         send_byte(d, a);
         chk(a, "R5 data ack", a, 1);
         model[m_idx] = d;
         m_idx = next_idx(m_idx, m_inc);
      end
      bus_stop();
      check_bank(m_inc ? "R7 burst write" : "R6 fixed write");
   endtask

   task automatic do_read(input int n, input string req);
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte(addr_byte(strap, 1'b1), a);
      chk(a, "R2 read address ack", a, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n-1, d);
         chk(d === model[m_idx], req, d, model[m_idx]);
         m_idx = next_idx(m_idx, m_inc);
      end
      tick(Q);
      chk(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic a;
      logic [7:0] d;
      void'($urandom(32'd4242));
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;
      tick(5);
      rst_n = 1'b1;
      tick(10);
      // R1 reset state
      chk(regs == '0, "R1 bank cleared", regs[31:0], 0);
      chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
      chk(spi_mode == 1'b0, "R1 mode flag", spi_mode, 0);
      do_read(1, "R1 read index 0 after reset");

      // R7 wrap directed
      do_write(8'h8E, 4);
      // R6 fixed register with reserved bits set
      do_write(8'h75, 3);
      // R11 read uses index left by previous transfer
      do_read(2, "R11 index persists");

      // random mix
      for (int t = 0; t < 24; t++) begin
         if ($urandom_range(0, 1) == 0) begin
            do_write(8'($urandom), $urandom_range(1, 5));
         end else begin
            if ($urandom_range(0, 1) == 0) begin
               d = {1'($urandom), 3'($urandom), 4'($urandom)};
               bus_start();
               send_byte(addr_byte(strap, 1'b0), a);
               chk(a, "R4 index-only ack", a, 1);
               send_byte(d, a);
               m_idx = d[3:0];
               m_inc = d[7];
            end
            do_read($urandom_range(1, 5), "R8 read data");
         end
      end

      // R3 mismatched address ignored
      bus_start();
      send_byte(8'h5A, a);
      chk(!a, "R3 mismatch nack", a, 0);
      send_byte(8'h03, a);
      chk(!a, "R3 later byte ignored", a, 0);
      send_byte(8'hC3, a);
      bus_stop();
      check_bank("R3 no write on mismatch");

      // R9 START mid-byte drops the byte
      bus_start();
      send_byte(addr_byte(strap, 1'b0), a);
      send_byte(8'h02, a);
      m_idx = 4'h2; m_inc = 1'b0;
      for (int i = 0; i < 4; i++) bit_out(1'b1);
      bus_start();
      bus_stop();
      check_bank("R9 aborted byte not written");

      // R2 strap high changes address
      strap = 1'b1;
      tick(10);
      bus_start();
      send_byte(addr_byte(1'b0, 1'b0), a);
      chk(!a, "R2 old address rejected", a, 0);
      bus_stop();
      do_write(8'h0B, 2);

      // R10 strap fall switches mode
      strap = 1'b0;
      tick(10);
      chk(spi_mode == 1'b1, "R10 mode set", spi_mode, 1);
      bus_start();
      send_byte(addr_byte(1'b0, 1'b0), a);
      chk(!a, "R10 no ack in spi mode", a, 0);
      send_byte(8'h01, a);
      send_byte(8'hEE, a);
      bus_stop();
      check_bank("R10 no write in spi mode");
      strap = 1'b1;
      tick(10);
      chk(spi_mode == 1'b1, "R10 flag sticky", spi_mode, 1);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule